// File: doc/BRIEF.md
# ADC Pacer and Burst Trigger Controller

This block decides when an acquisition front end starts each A/D conversion. A scan pacer counts out the scan interval. A burst sequencer spaces the conversions inside one scan. Both count ticks of an internal reference derived from the system clock. Software programs the start source of the pacer, the start source of a burst, the source of conversions, the two periods, the reference enable and the index of the last channel-list entry. A read of the control address arms the pacer, and a write of zero to that address halts it.

Each conversion produces a one-cycle `conv_strobe`. The channel-list index of that conversion appears on `conv_chan` in the same cycle. A single-channel scan takes its conversions straight from the pacer. A multi-channel scan lets each pacer tick open a burst that issues one conversion per entry of the channel list. A burst request that arrives while a burst is still running is dropped and latches a sticky overrun flag. External trigger inputs are synchronous one-cycle pulses.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset `conv_strobe`, `burst_active` and `overrun` are 0, `conv_chan` is 0, the pacer is stopped, the conversion source is off and the reference enable (address 0x6) is 0.
- R2: With the reference ticking every clock, conversion source 1 (pacer, address 0x3), pacer start source 0 (software, address 0x1) and pacer period value P (address 0x4, 24 bits), a read of address 0x0 in cycle c gives a strobe in cycle c+P+2 and every P+1 cycles after that.
- R3: Each strobe carries on `conv_chan` the channel index of that conversion. The index counts 0,1,... up to the last-entry value held at address 0x7 and then wraps to 0.
- R4: With conversion source 2 (burst) and burst start source 1 (pacer tick, address 0x2), a pacer tick in cycle T gives L = last+1 strobes at T+1+m(B+1) for m = 1..L, where B is the 10-bit burst period (address 0x5). `burst_active` is 1 from cycle T+1 through cycle T+L(B+1).
- R5: A burst start that arrives while a burst is active does not change the number or timing of its conversions and sets `overrun`.
- R6: Any write to address 0x8 clears `overrun`.
- R7: With pacer start source 1 (external), a read of address 0x0 only arms the pacer. A pulse on `ext_pacer_trig` in cycle c then gives the first strobe in cycle c+P+2.
- R8: Writing 0 to address 0x0 halts the pacer and aborts any burst, so no strobes follow.
- R9: With conversion source 0 (off), no strobe occurs while the pacer runs.
- R10: While the reference enable is 0, both counters hold and no strobes occur. Writing 1 resumes counting.
- R11: With burst start source 2, a pulse on `ext_burst_trig` in cycle c while idle gives strobes at c+1+m(B+1), m = 1..L.
- R12: Writing address 0x7 resets the channel pointer, so the next strobe carries index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms the pacer at address 0x0) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | PACER_W (24) | Register write data |
| ext_pacer_trig | input | 1 | External pacer start pulse |
| ext_burst_trig | input | 1 | External burst start pulse |
| conv_strobe | output | 1 | One-cycle conversion trigger |
| conv_chan | output | CH_W (4) | Channel-list index of the current conversion |
| burst_active | output | 1 | A burst is in progress |
| overrun | output | 1 | Sticky flag for a dropped burst start |

## Verification
The hardest state to reach is a burst start that lands while a burst is still running. With pacer-driven bursts the spacing is fixed, so this needs a mistuned period. The bench therefore switches the burst source to the external pulse and fires it again two cycles into a burst. It then confirms that exactly L strobes still arrive on their original schedule, that `overrun` rises, and that a write to the clear address drops it. The periodic modes are swept over small pacer, burst and channel-list values. Every cycle of each window is compared against positions computed from the period arithmetic.

// File: rtl/adc_trig_pkg.sv
// Shared register addresses, source encodings and event bundle for the
// conversion trigger controller. Assumes a 4-bit register address.
package adc_trig_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADR_CTL    = 4'h0;
    localparam logic [ADDR_W-1:0] ADR_PSTART = 4'h1;
    localparam logic [ADDR_W-1:0] ADR_BSRC   = 4'h2;
    localparam logic [ADDR_W-1:0] ADR_CSRC   = 4'h3;
    localparam logic [ADDR_W-1:0] ADR_PPER   = 4'h4;
    localparam logic [ADDR_W-1:0] ADR_BPER   = 4'h5;
    localparam logic [ADDR_W-1:0] ADR_REFEN  = 4'h6;
    localparam logic [ADDR_W-1:0] ADR_CHLAST = 4'h7;
    localparam logic [ADDR_W-1:0] ADR_OVRCLR = 4'h8;

    localparam logic       PSTART_SW  = 1'b0;
    localparam logic       PSTART_EXT = 1'b1;
    localparam logic [1:0] BSRC_PACER = 2'd1;
    localparam logic [1:0] BSRC_EXT   = 2'd2;
    localparam logic [1:0] CSRC_OFF   = 2'd0;
    localparam logic [1:0] CSRC_PACER = 2'd1;
    localparam logic [1:0] CSRC_BURST = 2'd2;

    typedef struct packed {
        logic pacer_arm;   // read of the control address
        logic pacer_halt;  // write of zero to the control address
        logic chan_load;   // new last-entry value written
        logic ovr_clr;     // overrun clear write
    } reg_evt_t;
endpackage

// File: rtl/adc_trig_regs.sv
// Configuration register file and access-event decoder.
// Assumes PACER_W is the widest field and that the bus presents one access per cycle.
module adc_trig_regs
    import adc_trig_pkg::*;
#(
    parameter int PACER_W = 24,
    parameter int BURST_W = 10,
    parameter int CH_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [PACER_W-1:0] reg_wdata,
    output logic               pstart_src,
    output logic [1:0]         burst_src,
    output logic [1:0]         conv_src,
    output logic [PACER_W-1:0] pacer_per,
    output logic [BURST_W-1:0] burst_per,
    output logic               ref_en,
    output logic [CH_W-1:0]    chan_last,
    output reg_evt_t           evt
);
    // Holds the configuration fields written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pstart_src <= PSTART_SW;
            burst_src  <= 2'd0;
            conv_src   <= CSRC_OFF;
            pacer_per  <= '0;
            burst_per  <= '0;
            ref_en     <= 1'b0;
            chan_last  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                ADR_PSTART: pstart_src <= reg_wdata[0];
                ADR_BSRC:   burst_src  <= reg_wdata[1:0];
                ADR_CSRC:   conv_src   <= reg_wdata[1:0];
                ADR_PPER:   pacer_per  <= reg_wdata;
                ADR_BPER:   burst_per  <= reg_wdata[BURST_W-1:0];
                ADR_REFEN:  ref_en     <= reg_wdata[0];
                ADR_CHLAST: chan_last  <= reg_wdata[CH_W-1:0];
                default:    ;
            endcase
        end
    end

    // Turns accesses into one-cycle control events.
    always_comb begin
        evt.pacer_arm  = reg_rd && (reg_addr == ADR_CTL);
        evt.pacer_halt = reg_wr && (reg_addr == ADR_CTL) && (reg_wdata == '0);
        evt.chan_load  = reg_wr && (reg_addr == ADR_CHLAST);
        evt.ovr_clr    = reg_wr && (reg_addr == ADR_OVRCLR);
    end
endmodule

// File: rtl/adc_trig_period_cnt.sv
// Reloading down counter. A value of N-1 gives one tick every N steps, and
// a value of 0 ticks on every step. Assumes load takes priority over counting.
module adc_trig_period_cnt #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         run,
    input  logic         step,
    input  logic [W-1:0] period,
    output logic         tick
);
    localparam logic [W-1:0] ONE = W'(1);
    logic [W-1:0] cnt;

    // Counts down on each enabled step and reloads at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= period;
        else if (run && step) cnt <= (cnt == '0) ? period : cnt - ONE;
    end

    // Flags the step on which the count expires.
    assign tick = run && step && !load && (cnt == '0);
endmodule

// File: rtl/adc_trig_burst.sv
// Burst sequencer: after a start it issues one burst tick per period, one for
// each channel-list entry, and then goes idle. A start while busy is dropped
// and latched as overrun.
module adc_trig_burst
    import adc_trig_pkg::*;
#(
    parameter int BURST_W = 10,
    parameter int CH_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               abort,
    input  logic               step,
    input  logic [BURST_W-1:0] period,
    input  logic [CH_W-1:0]    chan_last,
    input  logic               ovr_clr,
    output logic               active,
    output logic               overrun,
    output logic               burst_tick
);
    localparam logic [CH_W-1:0] ONE = CH_W'(1);
    logic [CH_W-1:0] done;
    logic            accept;

    assign accept = start && !active;

    adc_trig_period_cnt #(.W(BURST_W)) u_bcnt (
        .clk(clk), .rst_n(rst_n), .load(accept), .run(active),
        .step(step), .period(period), .tick(burst_tick)
    );

    // Tracks burst occupancy and the number of conversions already issued.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            active <= 1'b0;
            done   <= '0;
        end else if (accept) begin
            active <= 1'b1;
            done   <= '0;
        end else if (burst_tick) begin
            if (done == chan_last) begin
                active <= 1'b0;
                done   <= '0;
            end else begin
                done <= done + ONE;
            end
        end
    end

    // Sticky overrun flag; a new drop wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                         overrun <= 1'b0;
        else if (start && active && !abort) overrun <= 1'b1;
        else if (ovr_clr)                   overrun <= 1'b0;
    end

    assert_last_tick_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_tick && done == chan_last && !start && !abort) |=> !active);
    assert_busy_start_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && active && !abort) |=> overrun);
    assert_clear_drops_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_clr && !(start && active)) |=> !overrun);
    assert_idle_start_opens_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !active && !abort) |=> active);
endmodule

// File: rtl/adc_trig_ctrl.sv
// Top of the conversion trigger controller. It derives the reference tick,
// runs the pacer arm/halt state, chains pacer -> burst -> conversion and steps
// the channel pointer. External triggers are assumed synchronous one-cycle pulses.
module adc_trig_ctrl
    import adc_trig_pkg::*;
#(
    parameter int PACER_W = 24,
    parameter int BURST_W = 10,
    parameter int CH_W    = 4,
    parameter int REF_DIV = 25
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [3:0]         reg_addr,
    input  logic [PACER_W-1:0] reg_wdata,
    input  logic               ext_pacer_trig,
    input  logic               ext_burst_trig,
    output logic               conv_strobe,
    output logic [CH_W-1:0]    conv_chan,
    output logic               burst_active,
    output logic               overrun
);
    localparam logic [CH_W-1:0] CH_ONE = CH_W'(1);

    logic               pstart_src, ref_en, ref_tick, step;
    logic [1:0]         burst_src, conv_src;
    logic [PACER_W-1:0] pacer_per;
    logic [BURST_W-1:0] burst_per;
    logic [CH_W-1:0]    chan_last, chan_ptr;
    reg_evt_t           evt;
    logic               running, armed, pacer_go, pacer_tick;
    logic               burst_start, burst_tick, fire;

    adc_trig_regs #(.PACER_W(PACER_W), .BURST_W(BURST_W), .CH_W(CH_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pstart_src(pstart_src),
        .burst_src(burst_src), .conv_src(conv_src), .pacer_per(pacer_per),
        .burst_per(burst_per), .ref_en(ref_en), .chan_last(chan_last), .evt(evt)
    );

    // Reference tick: every clock, or one clock in REF_DIV.
    generate
        if (REF_DIV <= 1) begin : g_ref_direct
            assign ref_tick = 1'b1;
        end else begin : g_ref_div
            localparam int DW = $clog2(REF_DIV);
            localparam logic [DW-1:0] LAST = DW'(REF_DIV - 1);
            logic [DW-1:0] div_cnt;
            // Divides the system clock down to the reference rate.
            always_ff @(posedge clk) begin
                if (!rst_n || div_cnt == LAST) div_cnt <= '0;
                else                           div_cnt <= div_cnt + DW'(1);
            end
            assign ref_tick = (div_cnt == LAST);
        end
    endgenerate

    assign step = ref_tick && ref_en;

    // A software start goes at once on the read; an external start waits for the armed pulse.
    assign pacer_go = !evt.pacer_halt &&
                      ((evt.pacer_arm && pstart_src == PSTART_SW) ||
                       (armed && ext_pacer_trig));

    // Pacer run/arm state: halt first, then start, then arm.
    always_ff @(posedge clk) begin
        if (!rst_n || evt.pacer_halt) begin
            running <= 1'b0;
            armed   <= 1'b0;
        end else if (pacer_go) begin
            running <= 1'b1;
            armed   <= 1'b0;
        end else if (evt.pacer_arm) begin
            armed   <= 1'b1;
        end
    end

    adc_trig_period_cnt #(.W(PACER_W)) u_pcnt (
        .clk(clk), .rst_n(rst_n), .load(pacer_go), .run(running),
        .step(step), .period(pacer_per), .tick(pacer_tick)
    );

    assign burst_start = (burst_src == BSRC_PACER && pacer_tick) ||
                         (burst_src == BSRC_EXT && ext_burst_trig);

    adc_trig_burst #(.BURST_W(BURST_W), .CH_W(CH_W)) u_burst (
        .clk(clk), .rst_n(rst_n), .start(burst_start), .abort(evt.pacer_halt),
        .step(step), .period(burst_per), .chan_last(chan_last),
        .ovr_clr(evt.ovr_clr), .active(burst_active), .overrun(overrun),
        .burst_tick(burst_tick)
    );

    assign fire = (conv_src == CSRC_PACER && pacer_tick) ||
                  (conv_src == CSRC_BURST && burst_tick);

    // Registers the strobe and its channel, and steps the pointer with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_strobe <= 1'b0;
            conv_chan   <= '0;
            chan_ptr    <= '0;
        end else begin
            conv_strobe <= fire;
            if (fire) conv_chan <= chan_ptr;
            if (evt.chan_load)  chan_ptr <= '0;
            else if (fire)      chan_ptr <= (chan_ptr == chan_last) ? '0 : chan_ptr + CH_ONE;
        end
    end

    assert_chan_in_list_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |-> (conv_chan <= $past(chan_last)));
    assert_halt_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt.pacer_halt |=> !running);
    assert_off_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |-> ($past(conv_src) != CSRC_OFF));
    assert_ref_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_en |-> (!pacer_tick && !burst_tick));
endmodule

// File: tb/adc_trig_ctrl_bench.sv
`timescale 1ns/1ps
module adc_trig_ctrl_bench;
    localparam int CH_W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [23:0] reg_wdata = '0;
    logic        ext_pacer_trig = 1'b0, ext_burst_trig = 1'b0;
    logic        conv_strobe, burst_active, overrun;
    logic [CH_W-1:0] conv_chan;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_trig_ctrl #(.PACER_W(24), .BURST_W(10), .CH_W(CH_W), .REF_DIV(1)) u_adc_trig_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ext_pacer_trig(ext_pacer_trig),
        .ext_burst_trig(ext_burst_trig), .conv_strobe(conv_strobe),
        .conv_chan(conv_chan), .burst_active(burst_active), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // All drive tasks start just after a falling edge and end on the next one.
    task automatic wr(input int a, input int d);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 24'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_ctl();
        reg_rd = 1'b1; reg_addr = 4'h0;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic cfg(input int bs, input int cs, input int p, input int b, input int l);
        wr(0, 0); wr(3, cs); wr(2, bs); wr(4, p); wr(5, b); wr(7, l - 1); wr(1, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic quiet(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(conv_strobe == 1'b0, req, int'(conv_strobe), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int pl[4] = '{0, 1, 2, 5};
        int bl[3] = '{6, 9, 13};
        int cnt;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(conv_strobe == 0, "R1 strobe", int'(conv_strobe), 0);
        chk(burst_active == 0, "R1 burst_active", int'(burst_active), 0);
        chk(overrun == 0, "R1 overrun", int'(overrun), 0);
        chk(conv_chan == 0, "R1 conv_chan", int'(conv_chan), 0);
        quiet(5, "R1 idle after reset");
        wr(6, 1);

        // R2/R3: pacer-driven conversions
        for (int a = 0; a < 4; a++) begin
            for (int l = 1; l <= 3; l++) begin
                int p = pl[a];
                cfg(0, 1, p, 0, l);
                rd_ctl();
                for (int i = 1; i <= 30; i++) begin
                    bit e;
                    @(negedge clk);
                    e = (i % (p + 1)) == 0;
                    chk(conv_strobe == e, "R2 pacer strobe timing", int'(conv_strobe), int'(e));
                    if (e && conv_strobe)
                        chk(int'(conv_chan) == ((i / (p + 1)) - 1) % l, "R3 channel order",
                            int'(conv_chan), ((i / (p + 1)) - 1) % l);
                end
            end
        end

        // R4: pacer-started bursts
        for (int a = 0; a < 3; a++) begin
            for (int b = 0; b <= 2; b++) begin
                for (int l = 1; l <= 3; l++) begin
                    int p = bl[a];
                    if (l * (b + 1) <= p) begin
                        cfg(1, 2, p, b, l);
                        rd_ctl();
                        for (int i = 1; i <= 3 * (p + 1) + 2; i++) begin
                            int r, j;
                            bit es, ea;
                            @(negedge clk);
                            j = i / (p + 1); r = i % (p + 1);
                            ea = (j >= 1) && (r < l * (b + 1));
                            es = (j >= 1) && (r > 0) && (r % (b + 1) == 0) && (r / (b + 1) <= l);
                            chk(conv_strobe == es, "R4 burst strobe timing", int'(conv_strobe), int'(es));
                            chk(burst_active == ea, "R4 burst_active window", int'(burst_active), int'(ea));
                            if (es && conv_strobe)
                                chk(int'(conv_chan) == r / (b + 1) - 1, "R4 burst channel",
                                    int'(conv_chan), r / (b + 1) - 1);
                        end
                        chk(overrun == 0, "R5 no overrun when spaced", int'(overrun), 0);
                    end
                end
            end
        end

        // R11/R5/R6: external burst start, a second start while busy, then clear
        cfg(2, 2, 0, 3, 3);
        ext_burst_trig = 1'b1; @(negedge clk); ext_burst_trig = 1'b0;
        cnt = 0;
        for (int i = 1; i <= 20; i++) begin
            bit e;
            if (i == 2) ext_burst_trig = 1'b1;
            @(negedge clk);
            ext_burst_trig = 1'b0;
            e = (i % 4 == 0) && (i / 4 <= 3);
            if (conv_strobe) cnt++;
            chk(conv_strobe == e, "R11 external burst timing", int'(conv_strobe), int'(e));
        end
        chk(cnt == 3, "R5 busy start adds no conversions", cnt, 3);
        chk(overrun == 1, "R5 overrun set", int'(overrun), 1);
        wr(8, 1);
        chk(overrun == 0, "R6 overrun cleared", int'(overrun), 0);

        // R7: external pacer start
        cfg(0, 1, 3, 0, 1);
        wr(1, 1);
        rd_ctl();
        quiet(12, "R7 armed pacer waits");
        ext_pacer_trig = 1'b1; @(negedge clk); ext_pacer_trig = 1'b0;
        for (int i = 1; i <= 12; i++) begin
            bit e;
            @(negedge clk);
            e = (i % 4) == 0;
            chk(conv_strobe == e, "R7 external pacer timing", int'(conv_strobe), int'(e));
        end

        // R8: halt stops everything
        wr(0, 0);
        @(negedge clk);
        quiet(20, "R8 halted");

        // R9: conversion source off
        cfg(0, 0, 1, 0, 1);
        rd_ctl();
        quiet(20, "R9 source off");

        // R10: reference disabled holds counters
        cfg(0, 1, 1, 0, 1);
        wr(6, 0);
        rd_ctl();
        quiet(20, "R10 reference held");
        wr(6, 1);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (conv_strobe) cnt++;
        end
        chk(cnt >= 9, "R10 resumes after enable", cnt, 10);

        // R12: reloading the list resets the pointer
        cfg(0, 1, 5, 0, 4);
        rd_ctl();
        cnt = 0;
        while (cnt < 2) begin
            @(negedge clk);
            if (conv_strobe) cnt++;
        end
        chk(conv_chan == 1, "R3 second entry", int'(conv_chan), 1);
        wr(7, 3);
        cnt = 0;
        while (cnt < 1) begin
            @(negedge clk);
            if (conv_strobe) cnt++;
        end
        chk(conv_chan == 0, "R12 pointer reset on list load", int'(conv_chan), 0);
        wr(0, 0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule